// File: doc/BRIEF.md
# Eight-Source Snapshot Round Arbiter

The arbiter collects data words from a group of sources that share one data bus. Each source signals that it holds a word by raising its own request flag. When the arbiter is idle it copies all request flags into a snapshot register at once. It then serves the sources held in that snapshot one per cycle, highest source number first. For each source it raises a one-cycle grant, which lets that source put its word on the shared bus. On the clock edge that ends the grant cycle it captures the word and tags it with the source number. The tagged record goes downstream with a one-cycle valid strobe.

A new snapshot is taken only after every source in the current one has been served. A request that appears mid-round therefore waits for the next round, even when its number is higher than the source being served. Every requesting source is served once per round.

Top module: `snap_arbiter`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `grant` is all zero and `rec_valid` is low. A reset in the middle of a round abandons that round.
- R2: While the snapshot is empty, `req` is copied into it on every clock edge. A source whose flag is captured at edge E is granted during the cycle that follows E, provided it is the highest captured number. With no request, `grant` stays zero.
- R3: Within one round, the captured sources are granted in strictly descending source number, with no idle cycle between them.
- R4: `grant` has at most one bit set, and each grant lasts exactly one cycle for each time that source appears in a snapshot.
- R5: The record is `rec_word = {source number (3 bits, upper), bus word (27 bits, lower)}`. The bus word is the value of `bus_data` at the clock edge that ends the grant cycle. The record appears on the cycle after the grant.
- R6: A request raised while a round is being served is not granted in that round. It is served in the next snapshot, and within that snapshot the normal order applies.
- R7: `rec_valid` is high for exactly one cycle for each grant, in the cycle after that grant, and is low otherwise.
- R8: After the last grant of a round there is one cycle with no grant, in which the snapshot is re-sampled, before the next round's first grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 8 | Per-source data-available flags, bit i for source i |
| bus_data | input | 27 | Shared data bus, driven by the granted source |
| grant | output | 8 | One-hot, one-cycle grant that opens a source's data port |
| rec_valid | output | 1 | One-cycle strobe for each new record |
| rec_word | output | 30 | Source number (bits 29:27) and captured word (bits 26:0) |

## Verification
The assertions assume that the granted source drives `bus_data` during its grant cycle. They also assume that a source drops its flag once it has been served; a flag that stays high is simply served again in the next round. The bench models each source this way. A source lowers its flag at the falling edge inside its grant cycle. New flags are raised only shortly after a falling edge, so the snapshot samples stable levels. Mid-round requests are placed while a snapshot is known to be non-empty, which makes the round boundary of R6 and R8 deterministic.

// File: rtl/snap_arb_pkg.sv
package snap_arb_pkg;

    // Default geometry of the arbiter.
    localparam int ARB_NUM_SRC = 8;
    localparam int ARB_DATA_W  = 27;

    // Whether the snapshot register is waiting to sample or is draining.
    typedef enum logic {
        PH_SAMPLE = 1'b0,
        PH_DRAIN  = 1'b1
    } arb_phase_e;

    // Number of bits needed to name one of n sources.
    function automatic int unsigned idx_width(int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/snap_store.sv
module snap_store
    import snap_arb_pkg::*;
#(
    parameter int NUM_SRC = ARB_NUM_SRC
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] req,
    input  logic [NUM_SRC-1:0] served,
    output logic [NUM_SRC-1:0] snap,
    output arb_phase_e         phase
);

    // An empty snapshot means a new sample is due.
    assign phase = arb_phase_e'(|snap);

    always_ff @(posedge clk) begin
        if (rst) begin
            snap <= '0;
        end else if (phase == PH_SAMPLE) begin
            snap <= req;
        end else begin
            // The source being granted leaves the snapshot on the capture edge.
            snap <= snap & ~served;
        end
    end

endmodule

// File: rtl/prio_pick.sv
module prio_pick
    import snap_arb_pkg::*;
#(
    parameter int NUM_SRC = ARB_NUM_SRC,
    parameter int IDX_W   = idx_width(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] pending,
    output logic [NUM_SRC-1:0] pick,
    output logic [IDX_W-1:0]   pick_idx,
    output logic               any
);

    // hit_above[i] is set when any source numbered i or higher is pending.
    logic [NUM_SRC:0] hit_above;

    assign hit_above[NUM_SRC] = 1'b0;

    for (genvar g = NUM_SRC - 1; g >= 0; g--) begin : g_chain
        assign hit_above[g] = hit_above[g+1] | pending[g];
        assign pick[g]      = pending[g] & ~hit_above[g+1];
    end

    assign any = hit_above[0];

    always_comb begin
        pick_idx = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pick[i]) pick_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/rec_stage.sv
module rec_stage
    import snap_arb_pkg::*;
#(
    parameter int DATA_W = ARB_DATA_W,
    parameter int IDX_W  = idx_width(ARB_NUM_SRC)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    fire,
    input  logic [IDX_W-1:0]        src_idx,
    input  logic [DATA_W-1:0]       bus_data,
    output logic                    rec_valid,
    output logic [IDX_W+DATA_W-1:0] rec_word
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_valid <= 1'b0;
            rec_word  <= '0;
        end else begin
            rec_valid <= fire;
            if (fire) begin
                rec_word <= {src_idx, bus_data};
            end
        end
    end

endmodule

// File: rtl/snap_arbiter.sv
module snap_arbiter
    import snap_arb_pkg::*;
#(
    parameter int NUM_SRC = ARB_NUM_SRC,
    parameter int DATA_W  = ARB_DATA_W
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic [NUM_SRC-1:0]                      req,
    input  logic [DATA_W-1:0]                       bus_data,
    output logic [NUM_SRC-1:0]                      grant,
    output logic                                    rec_valid,
    output logic [DATA_W+idx_width(NUM_SRC)-1:0]    rec_word
);

    localparam int IDX_W = idx_width(NUM_SRC);

    logic [NUM_SRC-1:0] snap;
    logic [NUM_SRC-1:0] pick;
    logic [IDX_W-1:0]   pick_idx;
    logic               pick_any;
    arb_phase_e         phase;
    logic               fire;

    snap_store #(.NUM_SRC(NUM_SRC)) u_store (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .served (pick),
        .snap   (snap),
        .phase  (phase)
    );

    prio_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick (
        .pending  (snap),
        .pick     (pick),
        .pick_idx (pick_idx),
        .any      (pick_any)
    );

    // Grants only come out while a snapshot is draining.
    assign fire  = pick_any && (phase == PH_DRAIN);
    assign grant = fire ? pick : '0;

    rec_stage #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rec (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .src_idx   (pick_idx),
        .bus_data  (bus_data),
        .rec_valid (rec_valid),
        .rec_word  (rec_word)
    );

endmodule

// File: rtl/snap_arbiter_chk.sv
module snap_arbiter_chk
    import snap_arb_pkg::*;
#(
    parameter int NUM_SRC = ARB_NUM_SRC,
    parameter int DATA_W  = ARB_DATA_W
) (
    input logic                                 clk,
    input logic                                 rst,
    input logic [DATA_W-1:0]                    bus_data,
    input logic [NUM_SRC-1:0]                   grant,
    input logic                                 rec_valid,
    input logic [DATA_W+idx_width(NUM_SRC)-1:0] rec_word
);

    localparam int IDX_W = idx_width(NUM_SRC);

    function automatic logic [IDX_W-1:0] grant_num(logic [NUM_SRC-1:0] v);
        grant_num = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (v[i]) grant_num = IDX_W'(i);
        end
    endfunction

    assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    assert_valid_follows_grant_R7: assert property (@(posedge clk) disable iff (rst)
        (|grant) |=> rec_valid);

    assert_no_valid_without_grant_R7: assert property (@(posedge clk) disable iff (rst)
        !(|grant) |=> !rec_valid);

    assert_word_captured_R5: assert property (@(posedge clk) disable iff (rst)
        (|grant) |=> (rec_word[DATA_W-1:0] == $past(bus_data)));

    assert_tag_matches_R5: assert property (@(posedge clk) disable iff (rst)
        (|grant) |=> (rec_word[DATA_W+IDX_W-1:DATA_W] == grant_num($past(grant))));

    assert_descending_order_R3: assert property (@(posedge clk) disable iff (rst)
        (|grant) |=> (!(|grant) || (grant < $past(grant))));

endmodule

bind snap_arbiter snap_arbiter_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_data  (bus_data),
    .grant     (grant),
    .rec_valid (rec_valid),
    .rec_word  (rec_word)
);

// File: tb/test_snap_arbiter.sv
module test_snap_arbiter;
    import snap_arb_pkg::*;

    localparam int N  = ARB_NUM_SRC;
    localparam int DW = ARB_DATA_W;
    localparam int SW = idx_width(N);
    localparam int RW = DW + SW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  pend = '0;
    logic [DW-1:0] bus_data;
    logic [N-1:0]  grant;
    logic          rec_valid;
    logic [RW-1:0] rec_word;
    logic [DW-1:0] src_data [N];

    int            n_chk = 0;
    int            n_bad = 0;
    logic [RW-1:0] exp_q [$];
    bit            done = 1'b0;

    always #5 clk = ~clk;

    snap_arbiter i_snap_arbiter (
        .clk       (clk),
        .rst       (rst),
        .req       (pend),
        .bus_data  (bus_data),
        .grant     (grant),
        .rec_valid (rec_valid),
        .rec_word  (rec_word)
    );

    // Sources: the granted one drives the shared bus.
    always_comb begin
        bus_data = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) bus_data = src_data[i];
        end
    end

    function automatic logic [N-1:0] oh(int s);
        return N'(1) << s;
    endfunction

    function automatic logic [DW-1:0] mix(int k);
        return DW'((32'h01F3A5C7 * (k + 3)) ^ 32'h05A5A5A5);
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic raise(int s, logic [DW-1:0] d);
        src_data[s] = d;
        pend[s]     = 1'b1;
    endtask

    task automatic expect_rec(int s);
        exp_q.push_back({SW'(s), src_data[s]});
    endtask

    task automatic drain();
        int t = 0;
        while (exp_q.size() != 0 && t < 200) begin
            @(negedge clk);
            t++;
        end
        if (t >= 200) chk(1'b0, "R7 records missing", 64'(exp_q.size()), 64'd0);
        repeat (3) @(negedge clk);
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // A source drops its flag once granted.
    initial begin
        forever begin
            @(negedge clk);
            for (int i = 0; i < N; i++) begin
                if (grant[i]) pend[i] = 1'b0;
            end
        end
    end

    // Scoreboard monitor.
    initial begin
        logic prev_g;
        logic [RW-1:0] e;
        prev_g = 1'b0;
        forever begin
            @(negedge clk);
            if (rst) begin
                prev_g = 1'b0;
            end else begin
                if (prev_g || rec_valid)
                    chk(prev_g == rec_valid, "R7 strobe per grant", 64'(rec_valid), 64'(prev_g));
                if (rec_valid) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R6 unexpected record", 64'(rec_word), 64'd0);
                    end else begin
                        e = exp_q.pop_front();
                        chk(rec_word == e, "R3 R5 record", 64'(rec_word), 64'(e));
                    end
                end
                if (|grant) chk($onehot(grant), "R4 one grant", 64'(grant), 64'd0);
                prev_g = |grant;
            end
        end
    end

    initial begin
        #1_000_000;
        chk(1'b0, "R7 watchdog expired", 64'd0, 64'd1);
        report();
    end

    initial begin
        for (int i = 0; i < N; i++) src_data[i] = '0;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(grant == '0, "R1 grant in reset", 64'(grant), 64'd0);
        chk(rec_valid == 1'b0, "R1 valid in reset", 64'(rec_valid), 64'd0);
        #1 rst = 1'b0;

        // R2: no request, no grant
        repeat (4) begin
            @(negedge clk);
            chk(grant == '0, "R2 idle without request", 64'(grant), 64'd0);
        end

        // R2: latency from flag to grant
        @(negedge clk); #1;
        raise(4, 27'h0ABCDE); expect_rec(4);
        @(negedge clk);
        chk(grant == oh(4), "R2 grant after snapshot", 64'(grant), 64'(oh(4)));
        chk(rec_valid == 1'b0, "R5 record not before grant ends", 64'(rec_valid), 64'd0);
        @(negedge clk);
        chk(rec_valid == 1'b1, "R5 record after grant", 64'(rec_valid), 64'd1);
        drain();

        // R3: all sources at once
        @(negedge clk); #1;
        for (int s = 0; s < N; s++) raise(s, mix(s));
        for (int s = N - 1; s >= 0; s--) expect_rec(s);
        drain();

        // R3: sparse pattern 7,5,2,0
        @(negedge clk); #1;
        raise(0, mix(10)); raise(2, mix(12)); raise(5, mix(15)); raise(7, mix(17));
        expect_rec(7); expect_rec(5); expect_rec(2); expect_rec(0);
        drain();

        // R5: extreme bus words
        @(negedge clk); #1;
        raise(N - 1, '1); raise(0, '0);
        expect_rec(N - 1); expect_rec(0);
        drain();

        // R6 R8: late requests wait for the next round
        @(negedge clk); #1;
        raise(1, mix(21)); raise(3, mix(23));
        expect_rec(3); expect_rec(1);
        @(negedge clk);
        chk(grant == oh(3), "R3 first of round", 64'(grant), 64'(oh(3)));
        @(negedge clk);
        chk(grant == oh(1), "R3 second of round", 64'(grant), 64'(oh(1)));
        #1;
        raise(6, mix(26)); raise(3, mix(33));
        expect_rec(6); expect_rec(3);
        @(negedge clk);
        chk(grant == '0, "R8 gap between rounds", 64'(grant), 64'd0);
        @(negedge clk);
        chk(grant == oh(6), "R6 late request in next round", 64'(grant), 64'(oh(6)));
        @(negedge clk);
        chk(grant == oh(3), "R6 re-raised source next round", 64'(grant), 64'(oh(3)));
        drain();

        // R1: reset in the middle of a round
        @(negedge clk); #1;
        raise(2, mix(42)); raise(5, mix(45)); raise(6, mix(46));
        @(negedge clk);
        chk(grant == oh(6), "R3 first before reset", 64'(grant), 64'(oh(6)));
        #1;
        rst  = 1'b1;
        pend = '0;
        @(negedge clk);
        chk(grant == '0, "R1 grant after mid-round reset", 64'(grant), 64'd0);
        chk(rec_valid == 1'b0, "R1 valid after mid-round reset", 64'(rec_valid), 64'd0);
        #1 rst = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk(grant == '0 && rec_valid == 1'b0, "R1 round abandoned",
                64'({grant, rec_valid}), 64'd0);
        end

        chk(exp_q.size() == 0, "R7 all records seen", 64'(exp_q.size()), 64'd0);
        report();
    end

endmodule